// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block holds the routing configuration of an I/O interrupt controller. The configuration is a table of 24 routing entries, each 64 bits wide. Alongside the table sit an 8-bit identifier register and a read-only version word. Every one of these registers is reached through a narrow two-step window on a simple 32-bit bus. Software first writes a register number to a select location, then reads or writes a data location that acts on whichever register was selected.

Each 64-bit routing entry takes two select numbers. Numbering starts at 0x10, and the entry index is half the distance from that base. An even select number reaches the low 32 bits of the entry and an odd one reaches the high 32 bits. The whole table is also driven out in parallel, so dispatch logic can see every entry at all times without using the bus.

Bus reads are combinational in the same cycle. Writes take effect at the next rising clock edge.

Top module: `irq_route_regs`

## Requirements
- R1: A write to bus offset 0x00 loads data bits 7:0 into the select register. A read of offset 0x00 returns the select value in bits 7:0, with bits 31:8 zero.
- R2: With select 0x00, a write to the data window at offset 0x10 stores data bits 31:24 as the identifier. A window read returns the identifier in bits 31:24, with bits 23:0 zero.
- R3: With select 0x01, a window read returns 0x00170011: bits 7:0 hold the version code 0x11 and bits 23:16 hold the highest entry number, 23. Window writes with this select change nothing.
- R4: A select value s in the range 0x10 to 0x3F addresses entry (s - 0x10) >> 1. An odd s reaches entry bits 63:32 and an even s reaches entry bits 31:0, for both reads and writes.
- R5: A window write to one half of an entry replaces only that 32-bit half. The other half keeps its value.
- R6: After a synchronous active-low reset, every entry equals 0x0000_0000_0001_0000, which has only the mask bit 16 set. The identifier and the select register are zero.
- R7: Select values 0x02 to 0x0F and 0x40 to 0xFF read zero through the window. Window writes with these selects change no entry and do not change the identifier.
- R8: Reads of any bus offset other than 0x00 and 0x10 return zero. Writes to those offsets change no register.
- R9: Output route_table carries entry k in bits 64k+63 down to 64k. It shows a written value from the clock edge that commits the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the bus access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| route_table | output | 1536 | All 24 entries side by side, entry 0 in the lowest 64 bits |

## Verification
The hardest conditions to reach from the ports lie at the edges of the table range. Select 0x3F must still hit entry 23, while 0x40 and 0xFF must alias to nothing, including entry 0 after wrap. The half-write isolation must also be shown on entries whose two halves already differ. To reach these conditions, the bench first loads every entry with a pattern that differs per half and per index. It then makes ignored writes and one-half writes. After each one it compares the whole parallel table against a model and reads the affected halves back through the window.

// File: rtl/irq_route_pkg.sv
// Package irq_route_pkg
// Shared constants and the select-target type for the routing register window.
// Assumes a 32-bit bus word and 64-bit routing entries.
package irq_route_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned ENTRY_W      = 64;
    localparam int unsigned ID_W         = 8;
    localparam int unsigned MASK_BIT     = 16;
    localparam logic [7:0]  VERSION_CODE = 8'h11;

    // Kind of register that the current select value names
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_ID    = 2'd1,
        TGT_VER   = 2'd2,
        TGT_ENTRY = 2'd3
    } tgt_e;

endpackage

// File: rtl/irq_route_decode.sv
// Module irq_route_decode
// Decodes the held select value into a target kind, an entry index and a half,
// and produces one write strobe per entry half for window writes.
// Assumes the table base is even and at least 2.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned SEL_W       = 8,
    parameter int unsigned NUM_ENTRIES = 24,
    parameter int unsigned TABLE_BASE  = 16
) (
    input  logic [SEL_W-1:0]       sel,
    input  logic                   win_wr,
    output tgt_e                   tgt,
    output logic [SEL_W-1:0]       idx,
    output logic                   upper,
    output logic [NUM_ENTRIES-1:0] wr_lo,
    output logic [NUM_ENTRIES-1:0] wr_hi
);

    localparam logic [SEL_W-1:0] BASE  = SEL_W'(TABLE_BASE);
    localparam logic [SEL_W-1:0] LIMIT = SEL_W'(NUM_ENTRIES);

    logic [SEL_W-1:0] rel;

    // Distance of the select from the table base; index is half of it
    assign rel   = sel - BASE;
    assign idx   = rel >> 1;
    assign upper = rel[0];

    // Classify the select value
    always_comb begin
        if (sel == '0) begin
            tgt = TGT_ID;
        end else if (sel == SEL_W'(1)) begin
            tgt = TGT_VER;
        end else if ((sel >= BASE) && (idx < LIMIT)) begin
            tgt = TGT_ENTRY;
        end else begin
            tgt = TGT_NONE;
        end
    end

    // One strobe per entry half
    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_strobe
        assign wr_lo[k] = win_wr && (tgt == TGT_ENTRY) && (idx == SEL_W'(k)) && !upper;
        assign wr_hi[k] = win_wr && (tgt == TGT_ENTRY) && (idx == SEL_W'(k)) &&  upper;
    end

endmodule

// File: rtl/irq_route_entry.sv
// Module irq_route_entry
// Storage for one 64-bit routing entry, written one 32-bit half at a time.
// Assumes at most one half strobe is active per cycle.
module irq_route_entry
    import irq_route_pkg::*;
#(
    parameter logic [ENTRY_W-1:0] RESET_VAL = 64'h0000_0000_0001_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [WORD_W-1:0]  wdata,
    output logic [ENTRY_W-1:0] q
);

    logic rst_seen;

    // Half-word update of the entry, reset to the masked value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            if (wr_lo) q[WORD_W-1:0]       <= wdata;
            if (wr_hi) q[ENTRY_W-1:WORD_W] <= wdata;
        end
    end

    // Remembers that reset was active at the previous edge
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // A low-half write keeps the high half
    p_keep_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (q[ENTRY_W-1:WORD_W] == $past(q[ENTRY_W-1:WORD_W])));

    // A high-half write keeps the low half
    p_keep_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (q[WORD_W-1:0] == $past(q[WORD_W-1:0])));

    // Entry holds the masked value right after reset
    always @(posedge clk) begin
        if (rst_seen && rst_n) begin
            p_reset_masked_r6: assert (q == RESET_VAL);
        end
    end

endmodule

// File: rtl/irq_route_rdmux.sv
// Module irq_route_rdmux
// Selects the 32-bit word that the data window returns for the decoded target.
// Assumes idx is in range whenever tgt is TGT_ENTRY.
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int unsigned       SEL_W        = 8,
    parameter int unsigned       NUM_ENTRIES  = 24,
    parameter logic [WORD_W-1:0] VERSION_WORD = 32'h0017_0011
) (
    input  tgt_e                             tgt,
    input  logic [SEL_W-1:0]                 idx,
    input  logic                             upper,
    input  logic [ID_W-1:0]                  id_val,
    input  logic [NUM_ENTRIES*ENTRY_W-1:0]   table_flat,
    output logic [WORD_W-1:0]                win_data
);

    // Window read value by target kind
    always_comb begin
        win_data = '0;
        unique case (tgt)
            TGT_ID:  win_data = {id_val, {(WORD_W-ID_W){1'b0}}};
            TGT_VER: win_data = VERSION_WORD;
            TGT_ENTRY: begin
                for (int k = 0; k < int'(NUM_ENTRIES); k++) begin
                    if (idx == SEL_W'(k)) begin
                        win_data = upper ? table_flat[k*ENTRY_W+WORD_W +: WORD_W]
                                         : table_flat[k*ENTRY_W +: WORD_W];
                    end
                end
            end
            default: win_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_route_regs.sv
// Module irq_route_regs
// Indirect register window over the interrupt routing table: a select register
// at one offset, a data window at another, and the whole table out in parallel.
// Assumes single-cycle bus writes and combinational reads.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_ENTRIES = 24,
    parameter int unsigned SEL_W       = 8,
    parameter int unsigned ADDR_SEL    = 0,
    parameter int unsigned ADDR_WIN    = 16,
    parameter int unsigned TABLE_BASE  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic [WORD_W-1:0]              bus_wdata,
    output logic [WORD_W-1:0]              bus_rdata,
    output logic [NUM_ENTRIES*ENTRY_W-1:0] route_table
);

    localparam logic [ENTRY_W-1:0] ENTRY_RESET  = ENTRY_W'(1) << MASK_BIT;
    localparam logic [WORD_W-1:0]  VERSION_WORD = {8'h00, 8'(NUM_ENTRIES-1), 8'h00, VERSION_CODE};

    logic                   hit_sel;
    logic                   hit_win;
    logic                   win_wr;
    logic [SEL_W-1:0]       sel_q;
    logic [ID_W-1:0]        id_q;
    tgt_e                   tgt;
    logic [SEL_W-1:0]       idx;
    logic                   upper;
    logic [NUM_ENTRIES-1:0] wr_lo;
    logic [NUM_ENTRIES-1:0] wr_hi;
    logic [WORD_W-1:0]      win_data;

    // Bus offset match
    assign hit_sel = (bus_addr == ADDR_W'(ADDR_SEL));
    assign hit_win = (bus_addr == ADDR_W'(ADDR_WIN));
    assign win_wr  = bus_wr && hit_win;

    // Select register load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (bus_wr && hit_sel) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    // Identifier load from the top byte of window writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (win_wr && (tgt == TGT_ID)) begin
            id_q <= bus_wdata[WORD_W-1:WORD_W-ID_W];
        end
    end

    irq_route_decode #(
        .SEL_W       (SEL_W),
        .NUM_ENTRIES (NUM_ENTRIES),
        .TABLE_BASE  (TABLE_BASE)
    ) u_decode (
        .sel    (sel_q),
        .win_wr (win_wr),
        .tgt    (tgt),
        .idx    (idx),
        .upper  (upper),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi)
    );

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
        irq_route_entry #(
            .RESET_VAL (ENTRY_RESET)
        ) u_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[k]),
            .wr_hi (wr_hi[k]),
            .wdata (bus_wdata),
            .q     (route_table[k*ENTRY_W +: ENTRY_W])
        );
    end

    irq_route_rdmux #(
        .SEL_W        (SEL_W),
        .NUM_ENTRIES  (NUM_ENTRIES),
        .VERSION_WORD (VERSION_WORD)
    ) u_rdmux (
        .tgt        (tgt),
        .idx        (idx),
        .upper      (upper),
        .id_val     (id_q),
        .table_flat (route_table),
        .win_data   (win_data)
    );

    // Bus read value by offset
    always_comb begin
        if (hit_sel) begin
            bus_rdata = WORD_W'(sel_q);
        end else if (hit_win) begin
            bus_rdata = win_data;
        end else begin
            bus_rdata = '0;
        end
    end

    // Select register follows a write to its offset
    p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_sel) |=> (sel_q == $past(bus_wdata[SEL_W-1:0])));

    // Identifier follows a window write with select zero
    p_id_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && (sel_q == '0)) |=> (id_q == $past(bus_wdata[WORD_W-1:WORD_W-ID_W])));

    // At most one entry half is written per cycle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi}));

    // Writes to the version word or to undefined selects change nothing
    p_ignored_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ((tgt == TGT_NONE) || (tgt == TGT_VER)))
        |=> ($stable(route_table) && $stable(id_q)));

    // Writes to unmapped offsets change nothing
    p_other_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_sel && !hit_win)
        |=> ($stable(route_table) && $stable(sel_q) && $stable(id_q)));

endmodule

// File: tb/irq_route_regs_bench.sv
// Module irq_route_regs_bench
// Directed bench for the routing register window: one task per scenario,
// with a bench-side model of the table.
module irq_route_regs_bench;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N*64-1:0] route_table;

    logic [63:0] exp_tab [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_route_regs u_irq_route_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .route_table (route_table)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        bus_write(8'h00, {24'h0, s});
        bus_read(8'h10, d);
    endtask

    task automatic entry_write(input int k, input bit hi, input logic [31:0] d);
        bus_write(8'h00, 32'(8'h10 + 2*k + int'(hi)));
        bus_write(8'h10, d);
        if (hi) exp_tab[k][63:32] = d; else exp_tab[k][31:0] = d;
    endtask

    task automatic table_check(input string req);
        for (int k = 0; k < N; k++) chk(req, route_table[k*64 +: 64], exp_tab[k]);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(8'h00, d);
        chk("R6 select after reset", 64'(d), 64'h0);
        bus_read(8'h10, d);
        chk("R6 id after reset", 64'(d), 64'h0);
        for (int k = 0; k < N; k++) exp_tab[k] = 64'h0000_0000_0001_0000;
        table_check("R6 masked entries");
    endtask

    task automatic t_select;
        logic [31:0] d;
        bus_write(8'h00, 32'hFFFF_FF5A);
        bus_read(8'h00, d);
        chk("R1 select readback", 64'(d), 64'h5A);
    endtask

    task automatic t_id;
        logic [31:0] d;
        bus_write(8'h00, 32'h0);
        bus_write(8'h10, 32'hC3FF_FFFF);
        bus_read(8'h10, d);
        chk("R2 id readback", 64'(d), 64'hC300_0000);
        table_check("R2 id write leaves table");
    endtask

    task automatic t_version;
        logic [31:0] d;
        win_read(8'h01, d);
        chk("R3 version word", 64'(d), 64'h0017_0011);
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, d);
        chk("R3 version after write", 64'(d), 64'h0017_0011);
        table_check("R3 version write leaves table");
    endtask

    task automatic t_entries;
        logic [31:0] d;
        for (int k = 0; k < N; k++) begin
            entry_write(k, 1'b0, 32'hA000_0000 | 32'(k));
            entry_write(k, 1'b1, 32'h5000_0000 | 32'(k << 8));
        end
        table_check("R9 parallel table");
        for (int k = 0; k < N; k++) begin
            win_read(8'(8'h10 + 2*k), d);
            chk("R4 low half read", 64'(d), 64'(exp_tab[k][31:0]));
            win_read(8'(8'h11 + 2*k), d);
            chk("R4 high half read", 64'(d), 64'(exp_tab[k][63:32]));
        end
    endtask

    task automatic t_half;
        logic [31:0] d;
        entry_write(5, 1'b0, 32'h0BAD_F00D);
        chk("R5 high half kept", route_table[5*64+32 +: 32], 64'(32'h5000_0500));
        chk("R9 low half shown", route_table[5*64 +: 32], 64'(32'h0BAD_F00D));
        entry_write(23, 1'b1, 32'hFEED_0017);
        win_read(8'h3E, d);
        chk("R5 low half kept on top entry", 64'(d), 64'(32'hA000_0017));
        win_read(8'h3F, d);
        chk("R4 top entry high half", 64'(d), 64'(32'hFEED_0017));
        table_check("R5 table after half writes");
    endtask

    task automatic t_undefined;
        logic [31:0] d;
        logic [31:0] id_before;
        win_read(8'h00, id_before);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] s;
            s = (i == 0) ? 8'h40 : (i == 1) ? 8'hFF : (i == 2) ? 8'h0F : 8'h02;
            bus_write(8'h00, {24'h0, s});
            bus_write(8'h10, 32'hDEAD_BEEF);
            bus_read(8'h10, d);
            chk("R7 undefined select reads zero", 64'(d), 64'h0);
            table_check("R7 undefined write ignored");
        end
        win_read(8'h00, d);
        chk("R7 id unchanged", 64'(d), 64'(id_before));
    endtask

    task automatic t_other;
        logic [31:0] d;
        bus_write(8'h00, 32'h10);
        bus_write(8'h04, 32'h0000_0033);
        bus_write(8'h14, 32'h7777_7777);
        bus_write(8'h11, 32'h6666_6666);
        bus_read(8'h04, d);
        chk("R8 other offset reads zero", 64'(d), 64'h0);
        bus_read(8'h20, d);
        chk("R8 other offset reads zero", 64'(d), 64'h0);
        bus_read(8'h00, d);
        chk("R8 select unchanged", 64'(d), 64'h10);
        table_check("R8 table unchanged");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_id();
        t_version();
        t_entries();
        t_half();
        t_undefined();
        t_other();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule